// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad split into independent 32-bit banks. It serves a whole warp of lanes at once. Each lane presents an active flag, a write enable, a byte address and write data. The block finds the bank that each lane's word lives in, and in one cycle it serves every lane whose bank is free or whose address matches the address already chosen for that bank. Lanes that need different words of the same bank are pushed into later passes. The number of cycles an instruction takes therefore equals the largest count of distinct addresses in any single bank.

The requester sees a ready/valid handshake. When valid and ready are both high, the block captures the request and drops ready. It then runs one pass per clock. After the last pass it raises a single-cycle done pulse. Ready is high again in that same cycle, and the read data for every lane is valid on the output.

Top module: `banked_scratchpad`

## Requirements
- R1: A byte address selects its word by dropping the two low bits. The bank is word mod NUM_BANKS, which is byte-address bits [6:2] by default. The bank row is the word bits above the bank field. Byte-offset bits have no effect on which word is read or written.
- R2: When the active lanes use unit stride or any odd word stride, every lane lands in a distinct bank and the instruction takes exactly one pass.
- R3: When N distinct addresses fall in one bank, the instruction takes N passes, set by the worst bank. Word stride 2 gives 2 passes, stride 4 gives 4, and stride 32 gives 32.
- R4: When all lanes read one identical address, the block performs a single bank read, returns the word to every lane, and finishes in one pass.
- R5: Groups of lanes that each share one address, with each group in a different bank, are all served in the same pass.
- R6: Conflicts are evaluated across all lanes of the request. Lanes 0 and 16 reading different words of bank 0, with every other lane in its own bank, take 2 passes.
- R7: Inactive lanes take no part in conflict counting, and their write data never reaches memory. A request with no active lanes completes after one pass.
- R8: When several active lanes write the same address, the data of the highest-numbered of those lanes is kept.
- R9: A read returns the word as it was before the instruction. A write to the same address by another lane of the same instruction does not change what that read returns.
- R10: Ready goes low in the cycle after a request is accepted and stays low until the final pass. Done is then high for exactly one cycle, with ready high in that cycle.
- R11: After reset, ready is high, done is low, and all read data is zero.
- R12: The read-data slot of any lane that is inactive or writing reads zero at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_active_i | input | NUM_LANES | Per-lane active flag |
| req_we_i | input | NUM_LANES | Per-lane write (1) or read (0) |
| req_addr_i | input | NUM_LANES*ADDR_W | Per-lane byte address, lane l at bits [l*ADDR_W +: ADDR_W] |
| req_wdata_i | input | NUM_LANES*32 | Per-lane write word, lane l at bits [l*32 +: 32] |
| done_o | output | 1 | One-cycle pulse when the instruction completes |
| rd_data_o | output | NUM_LANES*32 | Per-lane read word, valid from done onward |

## Verification
Two functions can coincide in one pass: same-address sharing, and conflict splitting within a bank. Requests that combine them are sent, for example stride-32 accesses alongside a shared address, or a read and a write to one word together with inactive lanes aimed at a conflicting bank. Each request is judged on two things. The first is the number of cycles from acceptance to done, compared against the distinct-address count per bank computed in the bench. The second is the full read-data vector, compared against a shadow memory that keeps pre-instruction values for reads and applies highest-lane-wins for writes.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_OFF_W = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sp_state_e;
endpackage

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter
  import sp_pkg::*;
#(
  parameter int unsigned NUM_LANES = 32,
  parameter int unsigned BANK_W    = 5,
  parameter int unsigned ROW_W     = 5,
  parameter int unsigned BANK_ID   = 0
) (
  input  logic [NUM_LANES-1:0]        pending_i,
  input  logic [NUM_LANES*BANK_W-1:0] lane_bank_i,
  input  logic [NUM_LANES*ROW_W-1:0]  lane_row_i,
  input  logic [NUM_LANES-1:0]        lane_we_i,
  input  logic [NUM_LANES*WORD_W-1:0] lane_wdata_i,
  output logic [NUM_LANES-1:0]        served_o,
  output logic [ROW_W-1:0]            row_o,
  output logic                        wr_en_o,
  output logic [WORD_W-1:0]           wr_data_o
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [NUM_LANES-1:0] in_bank;
  logic                 found;

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++)
      in_bank[l] = pending_i[l] && (lane_bank_i[l*BANK_W +: BANK_W] == MY_BANK);
  end

  // lowest pending lane in this bank chooses the row for this pass
  always_comb begin
    found = 1'b0;
    row_o = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (!found && in_bank[l]) begin
        found = 1'b1;
        row_o = lane_row_i[l*ROW_W +: ROW_W];
      end
    end
  end

  // every lane on the chosen row is served; the last writer in lane order wins
  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      served_o[l] = found && in_bank[l] && (lane_row_i[l*ROW_W +: ROW_W] == row_o);
      if (served_o[l] && lane_we_i[l]) begin
        wr_en_o   = 1'b1;
        wr_data_o = lane_wdata_i[l*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/sp_bank_ram.sv
module sp_bank_ram
  import sp_pkg::*;
#(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = 5
) (
  input  logic              clk_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [ROWS];

  assign rd_data_o = mem_q[row_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[row_i] <= wr_data_i;
  end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import sp_pkg::*;
#(
  parameter int unsigned NUM_LANES = 32,
  parameter int unsigned NUM_BANKS = 32,
  parameter int unsigned BANK_ROWS = 32,
  parameter int unsigned ADDR_W    = BYTE_OFF_W + $clog2(NUM_BANKS) + $clog2(BANK_ROWS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [NUM_LANES-1:0]        req_active_i,
  input  logic [NUM_LANES-1:0]        req_we_i,
  input  logic [NUM_LANES*ADDR_W-1:0] req_addr_i,
  input  logic [NUM_LANES*WORD_W-1:0] req_wdata_i,
  output logic                        done_o,
  output logic [NUM_LANES*WORD_W-1:0] rd_data_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned ROW_W  = $clog2(BANK_ROWS);

  sp_state_e                  state_q;
  logic [NUM_LANES-1:0]        pend_q, we_q;
  logic [NUM_LANES*ADDR_W-1:0] addr_q;
  logic [NUM_LANES*WORD_W-1:0] wdata_q, rdata_q;
  logic                        done_q;

  logic [NUM_LANES*BANK_W-1:0] lane_bank;
  logic [NUM_LANES*ROW_W-1:0]  lane_row;
  logic [NUM_BANKS*NUM_LANES-1:0] bank_served;
  logic [NUM_BANKS*ROW_W-1:0]  bank_row;
  logic [NUM_BANKS-1:0]        bank_we;
  logic [NUM_BANKS*WORD_W-1:0] bank_wd, bank_rd;
  logic [NUM_LANES-1:0]        served, pend_nxt;
  logic                        busy, accept;

  assign busy        = (state_q == ST_BUSY);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && !busy;
  assign done_o      = done_q;
  assign rd_data_o   = rdata_q;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign lane_bank[l*BANK_W +: BANK_W] = addr_q[l*ADDR_W + BYTE_OFF_W +: BANK_W];
    assign lane_row[l*ROW_W +: ROW_W]    = addr_q[l*ADDR_W + BYTE_OFF_W + BANK_W +: ROW_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sp_bank_arbiter #(
      .NUM_LANES(NUM_LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(b)
    ) i_arb (
      .pending_i   (pend_q),
      .lane_bank_i (lane_bank),
      .lane_row_i  (lane_row),
      .lane_we_i   (we_q),
      .lane_wdata_i(wdata_q),
      .served_o    (bank_served[b*NUM_LANES +: NUM_LANES]),
      .row_o       (bank_row[b*ROW_W +: ROW_W]),
      .wr_en_o     (bank_we[b]),
      .wr_data_o   (bank_wd[b*WORD_W +: WORD_W])
    );

    sp_bank_ram #(.ROWS(BANK_ROWS), .ROW_W(ROW_W)) i_ram (
      .clk_i    (clk_i),
      .row_i    (bank_row[b*ROW_W +: ROW_W]),
      .wr_en_i  (bank_we[b] && busy),
      .wr_data_i(bank_wd[b*WORD_W +: WORD_W]),
      .rd_data_o(bank_rd[b*WORD_W +: WORD_W])
    );
  end

  // each lane belongs to one bank, so the per-bank masks are disjoint
  always_comb begin
    served = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      served = served | bank_served[b*NUM_LANES +: NUM_LANES];
    pend_nxt = pend_q & ~served;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_BUSY;
        pend_q  <= req_active_i;
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        rdata_q <= '0;
      end else if (busy) begin
        for (int l = 0; l < NUM_LANES; l++) begin
          if (served[l] && !we_q[l])
            rdata_q[l*WORD_W +: WORD_W] <=
              bank_rd[lane_bank[l*BANK_W +: BANK_W]*WORD_W +: WORD_W];
        end
        pend_q <= pend_nxt;
        if (pend_nxt == '0) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/banked_scratchpad_chk.sv
module banked_scratchpad_chk #(
  parameter int unsigned NUM_LANES = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_cnt <= 0;
    else if (req_ready_o) busy_cnt <= 0;
    else                  busy_cnt <= busy_cnt + 1;
  end

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);  // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_DONE_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);  // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(req_ready_o));  // R10
  AST_PASS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= NUM_LANES);  // R3
endmodule

bind banked_scratchpad banked_scratchpad_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .done_o     (done_o)
);

// File: tb/test_banked_scratchpad.sv
`timescale 1ns/1ps
module test_banked_scratchpad;
  localparam int L = 32, NB = 32, ROWS = 32, AW = 12, W = 32, WORDS = NB * ROWS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           req_valid = 1'b0, req_ready, done;
  logic [L-1:0]   req_active = '0, req_we = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*W-1:0] req_wdata = '0, rd_data;

  banked_scratchpad i_banked_scratchpad (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_active_i(req_active), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .done_o(done), .rd_data_o(rd_data)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] mem_m [WORDS];
  logic [L-1:0] act_v, we_v;
  int unsigned  addr_v [L];
  logic [W-1:0] wd_v [L];
  int           exp_pass_q [$];
  logic [L*W-1:0] exp_data_q [$];
  string        tag_q [$];
  event ev_issue, ev_done;

  task automatic check_int(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [L*W-1:0] got, logic [L*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_req();
    act_v = '0;
    we_v  = '0;
    for (int l = 0; l < L; l++) begin
      addr_v[l] = 0;
      wd_v[l]   = '0;
    end
  endtask

  task automatic set_lane(int l, bit a, bit w, int word, int off, logic [W-1:0] d);
    act_v[l]  = a;
    we_v[l]   = w;
    addr_v[l] = word * 4 + off;
    wd_v[l]   = d;
  endtask

  function automatic int word_of(int l);
    return (addr_v[l] >> 2) % WORDS;
  endfunction

  function automatic int model_passes();
    int worst = 1;
    for (int b = 0; b < NB; b++) begin
      int n = 0;
      for (int l = 0; l < L; l++) begin
        bit seen = 0;
        if (!act_v[l] || (word_of(l) % NB) != b) continue;
        for (int j = 0; j < l; j++)
          if (act_v[j] && word_of(j) == word_of(l)) seen = 1;
        if (!seen) n++;
      end
      if (n > worst) worst = n;
    end
    return worst;
  endfunction

  // driver: computes expectations, updates shadow memory, sends the request
  task automatic issue(string tag);
    logic [L*W-1:0] ed = '0;
    for (int l = 0; l < L; l++)
      if (act_v[l] && !we_v[l]) ed[l*W +: W] = mem_m[word_of(l)];
    exp_pass_q.push_back(model_passes());
    exp_data_q.push_back(ed);
    tag_q.push_back(tag);
    for (int l = 0; l < L; l++)
      if (act_v[l] && we_v[l]) mem_m[word_of(l)] = wd_v[l];
    @(negedge clk);
    req_active = act_v;
    req_we     = we_v;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW] = AW'(addr_v[l]);
      req_wdata[l*W +: W]  = wd_v[l];
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    -> ev_issue;
    @(ev_done);
  endtask

  // monitor: measures passes and compares results against the scoreboard
  initial begin
    forever begin
      int cnt;
      bit busy_ok;
      string tag;
      @(ev_issue);
      cnt = 0;
      busy_ok = 1;
      do begin
        @(negedge clk);
        cnt++;
        if (!done && req_ready) busy_ok = 0;
      end while (!done && cnt < 100);
      tag = tag_q.pop_front();
      check_int({tag, " passes"}, cnt, exp_pass_q.pop_front());
      check_vec({tag, " data"}, rd_data, exp_data_q.pop_front());
      check_int({tag, " R10 ready low while busy, high at done"},
                int'(busy_ok && req_ready && done), 1);
      -> ev_done;
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_int("R11 ready after reset", int'(req_ready), 1);
    check_int("R11 done after reset", int'(done), 0);
    check_vec("R11 rdata after reset", rd_data, '0);

    for (int blk = 0; blk < WORDS / L; blk++) begin
      clear_req();
      for (int l = 0; l < L; l++)
        set_lane(l, 1, 1, blk * L + l, 0, 32'hA500_0000 ^ ((blk * L + l) * 32'h9E37));
      issue("R2 fill unit stride");
    end

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 64 + l, 0, '0);
    issue("R2 unit stride read");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 3 * l + 5, 0, '0);
    issue("R2 stride 3");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 7 * l + 1, 0, '0);
    issue("R2 stride 7");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 2 * l, 0, '0);
    issue("R3 stride 2");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 4 * l, 0, '0);
    issue("R3 stride 4");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 32 * l + 3, 0, '0);
    issue("R3 stride 32");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 77, 0, '0);
    issue("R4 broadcast");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, (l < 16) ? 96 : 97, 0, '0);
    issue("R5 two groups");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, (l == 16) ? 32 : l, 0, '0);
    issue("R6 lanes 0 and 16");

    clear_req();
    for (int l = 0; l < L; l++)
      if (l < 3) set_lane(l, 1, 0, 32 * l + 9, 0, '0);
      else       set_lane(l, 0, 1, 32 * (l % 4), 0, 32'hDEAD_BEEF);
    issue("R7 inactive lanes ignored in conflicts");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 32 * (l % 4) + (l / 4), 0, '0);
    issue("R7 inactive writes left memory unchanged");
    clear_req();
    issue("R7 empty request");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 1, 200, 0, 32'h1000 + l);
    issue("R8 same-address writes");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 200, 0, '0);
    issue("R8 highest lane kept");

    clear_req();
    set_lane(0, 1, 0, 300, 0, '0);
    set_lane(1, 1, 1, 300, 0, 32'h5A5A_0001);
    set_lane(2, 1, 0, 300, 0, '0);
    set_lane(3, 1, 0, 332, 0, '0);
    issue("R9 read sees old word");
    clear_req();
    set_lane(0, 1, 0, 300, 0, '0);
    issue("R9 write landed");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, l % 2, 500 + l, 0, 32'hC0DE_0000 + l);
    issue("R12 write lanes return zero");

    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 1, 400 + l, l % 4, 32'h7700_0000 + l);
    issue("R1 byte offsets on write");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 400 + l, 0, '0);
    issue("R1 aligned readback");
    clear_req();
    for (int l = 0; l < L; l++) set_lane(l, 1, 0, 400 + (l % 2) * 32, 3, '0);
    issue("R1 bank wrap with offset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule